// File: doc/BRIEF.md
# Periodic Divider with Watchdog Timer

This block holds a 14-bit binary up-counter that advances once for every cycle in which the system clock enable is high. When the counter wraps from all ones back to zero, a periodic event flag is raised. The flag stays up until software clears it. A divider clear strobe zeroes only the four most significant stages. The ten low stages keep counting, so the phase of the fast periodic taps is kept.

A 4-bit watchdog counter advances on each rising transition of one of two divider stages. A select input picks the stage. With a 32768 Hz enable rate the divider event recurs every 500 ms. While the watchdog is enabled, the sixteenth tick after a zero count produces a single-cycle reset request, and the watchdog returns to zero. Software prevents this by pulsing the watchdog clear strobe often enough. With the enable low, the watchdog stays at zero.

Top module: `div_watchdog`

## Requirements
- R1: After the asynchronous active-low reset, the divider and watchdog counts are zero and both `evt_flag` and `rst_req` are 0.
- R2: The divider (bits 13..0) increments by one on each clock edge where `tick_en` is 1, and holds when `tick_en` is 0. From reset with `tick_en` held at 1, `evt_flag` is first seen at 1 after edge 16384.
- R3: `evt_flag` is set on the edge at which the divider wraps from 16383 to 0. It remains 1 until an edge with `evt_clr` high and no wrap. A wrap in the same cycle as `evt_clr` leaves the flag at 1.
- R4: A `div_clr` edge forces divider bits 13..10 to zero while bits 9..0 take their normal incremented value.
- R5: The watchdog advances by one for each rising transition (0 to 1 in the next state) of divider bit 9 when `wdt_slow` is 0, or of divider bit 13 when `wdt_slow` is 1. From reset with `tick_en` held at 1, the fast tap first rises on edge 512 and then every 1024 edges; the slow tap first rises on edge 8192.
- R6: A tick arriving while the watchdog count is 15 and `wdt_en` is 1 produces `rst_req` = 1 for exactly one cycle, and the count returns to 0.
- R7: A `wdt_clr` edge sets the watchdog count to 0 and suppresses any request. This also holds when a tick arrives on the same edge.
- R8: While `wdt_en` is 0, the watchdog count is held at 0 and `rst_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Divider count enable, one per system clock period |
| div_clr | input | 1 | Clears divider bits 13..10 |
| wdt_clr | input | 1 | Clears the watchdog count |
| evt_clr | input | 1 | Clears the divider event flag |
| wdt_slow | input | 1 | Watchdog tap select: 0 = bit 9, 1 = bit 13 |
| wdt_en | input | 1 | Watchdog enable |
| evt_flag | output | 1 | Sticky divider wrap event flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench times the first event from reset to the exact edge, so an off-by-one in the wrap detection or an extra register stage shows up as a shifted edge. A divider clear is applied mid-count; a design that clears every stage, or none, would move the next event by hundreds of cycles. The watchdog is brought to 15 on the fast tap and then switched to the slow tap. A design that detects a tap edge from a registered copy would issue a spurious request when the select changes, and one that ignores the select would fire about 8700 cycles early. Random strobes that coincide with wraps and ticks expose any reversal of the set-over-clear priority on the event flag, and any reversal of the clear-over-tick priority on the watchdog.

// File: rtl/div_watchdog.sv
module div_watchdog #(
  parameter int DIV_W    = 14,
  parameter int CLR_BITS = 4,
  parameter int WD_W     = 4,
  parameter int FAST_TAP = 9,
  parameter int SLOW_TAP = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic div_clr,
  input  logic wdt_clr,
  input  logic evt_clr,
  input  logic wdt_slow,
  input  logic wdt_en,
  output logic evt_flag,
  output logic rst_req
);
  localparam int KEEP_W = DIV_W - CLR_BITS;

  logic [DIV_W-1:0] div_q;
  logic [WD_W-1:0]  wd_q;

  wire [DIV_W:0]   div_inc  = {1'b0, div_q} + {{DIV_W{1'b0}}, tick_en};
  wire             div_wrap = div_inc[DIV_W];
  wire [DIV_W-1:0] div_nxt  = div_clr ? {{CLR_BITS{1'b0}}, div_inc[KEEP_W-1:0]}
                                      : div_inc[DIV_W-1:0];

  wire tap_now  = wdt_slow ? div_q[SLOW_TAP]   : div_q[FAST_TAP];
  wire tap_next = wdt_slow ? div_nxt[SLOW_TAP] : div_nxt[FAST_TAP];
  wire wd_tick  = tap_next & ~tap_now;
  wire wd_full  = &wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      evt_flag <= 1'b0;
    end else begin
      div_q <= div_nxt;
      if (div_wrap)     evt_flag <= 1'b1;
      else if (evt_clr) evt_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q    <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!wdt_en || wdt_clr) begin
        wd_q <= '0;
      end else if (wd_tick) begin
        wd_q <= wd_q + 1'b1;
        if (wd_full) rst_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/div_watchdog_chk.sv
module div_watchdog_chk #(
  parameter int DIV_W    = 14,
  parameter int CLR_BITS = 4,
  parameter int WD_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             div_clr,
  input logic             wdt_clr,
  input logic             evt_clr,
  input logic             wdt_en,
  input logic             evt_flag,
  input logic             rst_req,
  input logic [DIV_W-1:0] div_q,
  input logic [WD_W-1:0]  wd_q
);
  localparam int KEEP_W = DIV_W - CLR_BITS;

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !div_clr |=> $stable(div_q)); // R2
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !div_clr |=> div_q == DIV_W'($past(div_q) + 1'b1)); // R2
  AST_DIV_PART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr && !tick_en |=> (div_q[DIV_W-1:KEEP_W] == '0) &&
                            (div_q[KEEP_W-1:0] == $past(div_q[KEEP_W-1:0]))); // R4
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !evt_clr |=> evt_flag); // R3
  AST_EVT_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(tick_en) && (&($past(div_q)))); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6
  AST_REQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_q == '0); // R6
  AST_WDT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (wd_q == '0) && !rst_req); // R7
  AST_WDT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> (wd_q == '0) && !rst_req); // R8
  AST_WD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en && !wdt_clr |=> (wd_q == $past(wd_q)) ||
                           (wd_q == WD_W'($past(wd_q) + 1'b1))); // R5
endmodule

bind div_watchdog div_watchdog_chk #(
  .DIV_W(DIV_W), .CLR_BITS(CLR_BITS), .WD_W(WD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_clr(div_clr),
  .wdt_clr(wdt_clr), .evt_clr(evt_clr), .wdt_en(wdt_en),
  .evt_flag(evt_flag), .rst_req(rst_req), .div_q(div_q), .wd_q(wd_q)
);

// File: tb/div_watchdog_test.sv
module div_watchdog_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, div_clr = 1'b0, wdt_clr = 1'b0, evt_clr = 1'b0;
  logic wdt_slow = 1'b0, wdt_en = 1'b0;
  logic evt_flag, rst_req;

  int n_chk = 0, n_bad = 0;
  int m_div, m_wd;
  bit m_evt, m_req;
  bit done = 0;

  always #10 clk = ~clk;

  div_watchdog uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_clr(div_clr),
    .wdt_clr(wdt_clr), .evt_clr(evt_clr), .wdt_slow(wdt_slow), .wdt_en(wdt_en),
    .evt_flag(evt_flag), .rst_req(rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit bitof(input int v, input int k);
    return ((v >> k) & 1) != 0;
  endfunction

  task automatic model_edge();
    int nxt = m_div + (tick_en ? 1 : 0);
    bit wrap = nxt >= 16384;
    int tap = wdt_slow ? 13 : 9;
    bit rise;
    nxt = nxt % 16384;
    if (div_clr) nxt = nxt % 1024;
    rise = !bitof(m_div, tap) && bitof(nxt, tap);
    if (wrap) m_evt = 1;
    else if (evt_clr) m_evt = 0;
    m_req = 0;
    if (!wdt_en || wdt_clr) m_wd = 0;
    else if (rise) begin
      if (m_wd == 15) begin m_wd = 0; m_req = 1; end
      else m_wd = m_wd + 1;
    end
    m_div = nxt;
  endtask

  // inputs are set before this call, at a falling edge
  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R3 evt_flag vs model", int'(evt_flag), int'(m_evt));
    check("R6 rst_req vs model", int'(rst_req), int'(m_req));
  endtask

  task automatic set_in(input bit ce, input bit dc, input bit wc, input bit ec,
                        input bit sl, input bit we);
    tick_en = ce; div_clr = dc; wdt_clr = wc; evt_clr = ec; wdt_slow = sl; wdt_en = we;
  endtask

  task automatic do_reset();
    @(negedge clk);
    set_in(0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_div = 0; m_wd = 0; m_evt = 0; m_req = 0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 evt_flag after reset", int'(evt_flag), 0);
    check("R1 rst_req after reset", int'(rst_req), 0);
  endtask

  initial begin
    int first;
    void'($urandom(32'd1234));
    do_reset();

    // R2: first wrap exactly after edge 16384; idle cycles do not count
    set_in(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 50; i++) step();
    set_in(1, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 16384; i++) begin
      step();
      if (i == 16383) check("R2 no event before edge 16384", int'(evt_flag), 0);
      if (i == 16384) check("R2 event after edge 16384", int'(evt_flag), 1);
    end
    // R3: flag sticky, then cleared
    for (int i = 0; i < 20; i++) step();
    check("R3 flag held without clear", int'(evt_flag), 1);
    set_in(1, 0, 0, 1, 0, 0); step();
    check("R3 flag cleared", int'(evt_flag), 0);
    // R3: clear held across a wrap, set wins
    while (m_div != 16383) step();
    step();
    check("R3 set wins over clear", int'(evt_flag), 1);
    step();
    check("R3 clear after wrap", int'(evt_flag), 0);

    // R4: partial divider clear at count 16000
    do_reset();
    set_in(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16000; i++) step();
    set_in(1, 1, 0, 0, 0, 0); step();   // divider becomes 16001 % 1024 = 641
    set_in(1, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 15743; i++) begin
      step();
      if (i == 15742) check("R4 no event before low-bit wrap", int'(evt_flag), 0);
      if (i == 15743) check("R4 event timed from kept low bits", int'(evt_flag), 1);
    end

    // R5 R6: fast tap, request after edge 512 + 15*1024 = 15872
    do_reset();
    set_in(1, 0, 0, 0, 0, 1);
    first = 0;
    for (int i = 1; i <= 15880; i++) begin
      step();
      if (rst_req && first == 0) first = i;
    end
    check("R5 fast-tap request edge", first, 15872);
    check("R6 request lasts one cycle", int'(rst_req), 0);

    // R8: disabled watchdog never requests
    do_reset();
    set_in(1, 0, 0, 0, 0, 0);
    first = 0;
    for (int i = 0; i < 17000; i++) begin step(); if (rst_req) first = 1; end
    check("R8 no request while disabled", first, 0);

    // R7: periodic clears keep it quiet (some coincide with ticks)
    do_reset();
    first = 0;
    for (int i = 1; i <= 17000; i++) begin
      set_in(1, 0, (i % 1024) == 512, 0, 0, 1);
      step();
      if (rst_req) first = 1;
    end
    check("R7 no request with periodic clear", first, 0);

    // R5: count to 15 on fast tap (14848 edges), then switch to slow tap
    do_reset();
    set_in(1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 14848; i++) step();
    set_in(1, 0, 0, 0, 1, 1);
    first = 0;
    for (int i = 1; i <= 9728; i++) begin
      step();
      if (rst_req && first == 0) first = i;
    end
    check("R5 slow-tap request edge", first, 9728);

    // random mix
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      set_in(($urandom % 4) != 0, ($urandom % 3000) == 0, ($urandom % 9000) == 0,
             ($urandom % 400) == 0, ($urandom % 5000) == 0 ? ~wdt_slow : wdt_slow,
             ($urandom % 20000) == 0 ? 1'b0 : 1'b1);
      step();
    end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule